// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures how fast one clock is running. A source-select field picks one of up to 128 candidate clocks. A gate window of a programmable number of microseconds is timed from the reference clock through a 1 MHz tick. While the gate is open, the rising edges of the chosen clock are counted in that clock's own domain. When the window closes, the final count is handed back to the reference domain through a toggle handshake and latched into a read-only result word.

Software drives the block through four 32-bit register words. First it clears the control word. It then writes the duration, the source and the run and enable bits in one go. It polls the busy flag until it drops, clears enable, and reads the edge count. From that count it works out the frequency itself.

A continuous mode restarts the gate after every completion. An optional single-cycle interrupt marks each completion. No data stream passes through the block, so there is no back-pressure. The register port accepts a write on any cycle, and a read returns its word in the same cycle.

Top module: `freq_meter`

## Requirements
- R1: Byte offset 0x4 holds the control word and 0xC holds the result word. Offsets 0x0 and 0x8 read as zero, and writes to them change nothing. A write to the result word is ignored.
- R2: Control bits 15:0 hold D-1, and the gate then stays open for D microseconds, which is D·(REF_HZ/1 MHz) reference cycles. Busy stays high for at least that long and drops within 100 reference cycles after the window ends.
- R3: The control word reads back with these fields: enable in bit 16, continuous in bit 17, interrupt enable in bit 18, run in bit 19 and source select in bits 26:20. Run clears itself when a measurement starts. Run written without enable reads back as zero.
- R4: Bit 31 of the control word is a read-only busy flag. It is high from the write that sets run and enable until the result is written. Writing it has no effect.
- R5: The result word (bits 15:0) holds the rising-edge count of the selected clock over the gate. The count lies within 2 of D·f, where f is that clock's frequency in MHz.
- R6: The edge count saturates at 0xFFFF. A result of 0xFFFF marks an overflowed, invalid measurement.
- R7: With continuous set, a new gate starts after every completion and the result updates each time. Clearing enable stops the sequence.
- R8: The irq_o output goes high for exactly one reference cycle at each completion when interrupt enable is set. It never goes high otherwise.
- R9: Clearing enable during a measurement drops busy on the next cycle. The result word keeps its previous value, no interrupt is raised, and a later measurement runs normally.
- R10: After reset the control and result words read zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_clk_i | input | NUM_SRC | Candidate clocks to be measured |
| bus_addr_i | input | ADDR_W | Byte offset of the register word |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, same cycle |
| irq_o | output | 1 | Completion pulse, one cycle |

## Verification
The bench times the busy window against D·200 cycles. A meter that opens the gate for the raw field value instead of field+1 is one full microsecond out and fails this check. It also measures sources from 10 MHz to 125 MHz and checks the counts against D·f. Wrong source decoding or a wrong count carried across the clock-domain crossing shows up as counts that are off by hundreds of edges.

A 1 GHz source over 70 µs must read exactly 0xFFFF. A counter that wraps instead of saturating returns a small value. An abort midway through a window must leave the old result in place and raise no interrupt. A design that lets the late completion handshake through would overwrite the result or pulse irq_o.

In continuous mode the interrupt must repeat while the gate keeps restarting. The pulses must stop once enable is cleared.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GATE,
    ST_CLOSE,
    ST_WAIT
  } fm_state_e;

  // byte offsets of the register words
  localparam int OFS_CTRL = 4;
  localparam int OFS_RES  = 12;

  // control word bit positions
  localparam int BIT_EN   = 16;
  localparam int BIT_CONT = 17;
  localparam int BIT_IRQ  = 18;
  localparam int BIT_RUN  = 19;
  localparam int BIT_SEL  = 20;
  localparam int BIT_BUSY = 31;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fm_tick.sv
module fm_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_tick_chk
      // R2
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/fm_edge_cnt.sv
module fm_edge_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             mclk,
  input  logic             arst_n,
  input  logic             gate_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             tgl_o,
  output logic             echo_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [1:0]       rs_q;
  logic             m_rst_n;
  logic [2:0]       g_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hold_q;
  logic             tgl_q;
  logic             g_rise, g_fall;

  // reset release brought into the measured domain
  always_ff @(posedge mclk or negedge arst_n) begin
    if (!arst_n) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign m_rst_n = rs_q[1];

  always_ff @(posedge mclk or negedge m_rst_n) begin
    if (!m_rst_n) g_q <= '0;
    else          g_q <= {g_q[1:0], gate_i};
  end

  assign g_rise = g_q[1] & ~g_q[2];
  assign g_fall = ~g_q[1] & g_q[2];

  always_ff @(posedge mclk or negedge m_rst_n) begin
    if (!m_rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      if (g_rise)                       cnt_q <= '0;
      else if (g_q[1] && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      if (g_fall) begin
        hold_q <= cnt_q;
        tgl_q  <= ~tgl_q;
      end
    end
  end

  assign hold_o = hold_q;
  assign tgl_o  = tgl_q;
  assign echo_o = g_q[1];

  // R6
  sat_hold_chk: assert property (@(posedge mclk) disable iff (!m_rst_n)
    (cnt_q == CMAX && g_q[1] && g_q[2]) |=> (cnt_q == CMAX));
  // R5
  hold_stable_chk: assert property (@(posedge mclk) disable iff (!m_rst_n)
    !(~g_q[1] & g_q[2]) |=> $stable(hold_q));
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int DIV   = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             cont_i,
  input  logic             irq_en_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             echo_i,
  input  logic             tgl_i,
  output logic             gate_o,
  output logic             launch_o,
  output logic             act_o,
  output logic             res_we_o,
  output logic             irq_o
);
  fm_state_e        st_q;
  logic             gate_q, quiet_q, irq_q, tgl_prev_q;
  logic [DUR_W-1:0] tmr_q;
  logic             done_evt, launch, finish_ok, start, tick;

  assign done_evt  = tgl_i ^ tgl_prev_q;
  assign launch    = (st_q == ST_IDLE) && en_i && run_i;
  assign finish_ok = (st_q == ST_WAIT) && done_evt && en_i && !quiet_q;
  assign start     = launch | (finish_ok & cont_i);

  fm_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start),
    .tick_o (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      gate_q     <= 1'b0;
      quiet_q    <= 1'b0;
      irq_q      <= 1'b0;
      tgl_prev_q <= 1'b0;
      tmr_q      <= '0;
    end else begin
      tgl_prev_q <= tgl_i;
      irq_q      <= finish_ok & irq_en_i;
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q    <= ST_GATE;
          gate_q  <= 1'b1;
          tmr_q   <= dur_i;
          quiet_q <= 1'b0;
        end
        ST_GATE: begin
          if (!en_i) begin
            quiet_q <= 1'b1;
            st_q    <= ST_CLOSE;
          end else if (tick) begin
            if (tmr_q == '0) st_q <= ST_CLOSE;
            else             tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_CLOSE: begin
          if (!en_i) quiet_q <= 1'b1;
          // gate held until the measured domain has seen it open
          if (echo_i) begin
            gate_q <= 1'b0;
            st_q   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!en_i) quiet_q <= 1'b1;
          if (done_evt) begin
            if (finish_ok && cont_i) begin
              st_q   <= ST_GATE;
              gate_q <= 1'b1;
              tmr_q  <= dur_i;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gate_o   = gate_q;
  assign launch_o = launch;
  assign act_o    = (st_q != ST_IDLE) && !quiet_q;
  assign res_we_o = finish_ok;
  assign irq_o    = irq_q;

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R2
  gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> ($past(st_q) == ST_CLOSE));
  // R5
  done_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (st_q == ST_WAIT));
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int REF_HZ  = 200_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int NUM_SRC = 128,
  parameter int DUR_W   = 16,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] meas_clk_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_wr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);
  localparam int DIV   = REF_HZ / TICK_HZ;
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [31:0] USED_MASK = ((32'd1 << DUR_W) - 32'd1)
                                    | (32'hF << BIT_EN)
                                    | (((32'd1 << SEL_W) - 32'd1) << BIT_SEL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFS_RES);

  logic [DUR_W-1:0] dur_q;
  logic             en_q, cont_q, irq_en_q, run_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] res_q;
  logic             ctrl_wr;
  logic             unused_wbits;

  logic             mclk, gate, echo_m, echo_s, tgl_m, tgl_s;
  logic [CNT_W-1:0] hold;
  logic             launch, act, res_we, busy;

  assign ctrl_wr      = bus_wr_i && (bus_addr_i == A_CTRL);
  assign unused_wbits = ^(bus_wdata_i & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q    <= '0;
      en_q     <= 1'b0;
      cont_q   <= 1'b0;
      irq_en_q <= 1'b0;
      run_q    <= 1'b0;
      sel_q    <= '0;
    end else if (ctrl_wr) begin
      dur_q    <= bus_wdata_i[DUR_W-1:0];
      en_q     <= bus_wdata_i[BIT_EN];
      cont_q   <= bus_wdata_i[BIT_CONT];
      irq_en_q <= bus_wdata_i[BIT_IRQ];
      run_q    <= bus_wdata_i[BIT_RUN] & bus_wdata_i[BIT_EN];
      sel_q    <= bus_wdata_i[BIT_SEL +: SEL_W];
    end else if (launch) begin
      run_q <= 1'b0;
    end
  end

  // the count is stable whenever the completion event is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_we) res_q <= hold;
  end

  assign busy = run_q | (en_q & act);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[DUR_W-1:0]         = dur_q;
        bus_rdata_o[BIT_EN]            = en_q;
        bus_rdata_o[BIT_CONT]          = cont_q;
        bus_rdata_o[BIT_IRQ]           = irq_en_q;
        bus_rdata_o[BIT_RUN]           = run_q;
        bus_rdata_o[BIT_SEL +: SEL_W]  = sel_q;
        bus_rdata_o[BIT_BUSY]          = busy;
      end
      A_RES:   bus_rdata_o[CNT_W-1:0] = res_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign mclk = meas_clk_i[sel_q];

  fm_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .mclk   (mclk),
    .arst_n (rst_n),
    .gate_i (gate),
    .hold_o (hold),
    .tgl_o  (tgl_m),
    .echo_o (echo_m)
  );

  fm_sync #(.W(1)) u_echo_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (echo_m),
    .q_o   (echo_s)
  );

  fm_sync #(.W(1)) u_tgl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (tgl_m),
    .q_o   (tgl_s)
  );

  fm_ctrl #(.DUR_W(DUR_W), .DIV(DIV)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_q),
    .run_i    (run_q),
    .cont_i   (cont_q),
    .irq_en_i (irq_en_q),
    .dur_i    (dur_q),
    .echo_i   (echo_s),
    .tgl_i    (tgl_s),
    .gate_o   (gate),
    .launch_o (launch),
    .act_o    (act),
    .res_we_o (res_we),
    .irq_o    (irq_o)
  );

  // R9
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(res_q));
  // R3
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !ctrl_wr) |=> !run_q);
endmodule

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] mck = '0;
  logic [3:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, width_err = 0;
  bit irq_prev = 1'b0;

  always #2.5 clk = ~clk;
  always #50  mck[0]   = ~mck[0];    // 10 MHz
  always #10  mck[3]   = ~mck[3];    // 50 MHz
  always #20  mck[64]  = ~mck[64];   // 25 MHz
  always #4   mck[77]  = ~mck[77];   // 125 MHz
  always #0.5 mck[127] = ~mck[127];  // 1 GHz

  freq_meter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_clk_i  (mck),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr_en),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (irq && irq_prev) width_err++;
      irq_prev = irq;
    end
  end

  // rows: source, field value (D-1), expected edges D*f
  localparam int NV = 6;
  localparam int V_SEL [NV] = '{3, 77, 0, 64, 77, 3};
  localparam int V_DM1 [NV] = '{9, 3, 19, 0, 39, 0};
  localparam int V_EXP [NV] = '{500, 500, 200, 25, 5000, 50};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cw(int sel, int dm1, bit en, bit run, bit cont, bit ie);
    cw = (32'(dm1) & 32'hFFFF) | (32'(en) << 16) | (32'(cont) << 17)
       | (32'(ie) << 18) | (32'(run) << 19) | ((32'(sel) & 32'h7F) << 20);
  endfunction

  task automatic run_meas(input int sel, input int dm1, input bit ie,
                          output int cycles, output int res);
    logic [31:0] d;
    wr(4'h4, 32'h0);
    wr(4'h4, cw(sel, dm1, 1, 1, 0, ie));
    cycles = 0;
    do begin
      rd(4'h4, d);
      cycles++;
    end while (d[31] && cycles < 30000);
    wr(4'h4, 32'h0);
    rd(4'hC, d);
    res = int'(d[15:0]);
  endtask

  function automatic bit near(int act, int exp);
    near = (act >= exp - 2) && (act <= exp + 2);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc, res, base, r0;

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    rd(4'h4, d); chk(d == 0, "R10 ctrl", d, 0);
    rd(4'hC, d); chk(d == 0, "R10 result", d, 0);
    chk(irq == 1'b0, "R10 irq", irq, 0);
    // R1 unused words
    rd(4'h0, d); chk(d == 0, "R1 word0", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 word8", d, 0);

    // R5 and R2 over the vector table
    base = irq_cnt;
    for (int i = 0; i < NV; i++) begin
      run_meas(V_SEL[i], V_DM1[i], 1'b0, cyc, res);
      chk(near(res, V_EXP[i]), "R5 count", res, V_EXP[i]);
      chk(cyc >= (V_DM1[i] + 1) * 200 - 2 && cyc <= (V_DM1[i] + 1) * 200 + 100,
          "R2 busy window", cyc, (V_DM1[i] + 1) * 200);
    end
    chk(irq_cnt == base, "R8 no irq without enable", irq_cnt - base, 0);

    // R3 field readback, R4 busy while running, R8 one pulse
    base = irq_cnt;
    wr(4'h4, 32'h0);
    wr(4'h4, cw(77, 7, 1, 1, 0, 1));
    rd(4'h4, d);
    chk(d[19] == 1'b0, "R3 run self clear", d[19], 0);
    chk(d[16] == 1'b1 && d[18] == 1'b1 && d[17] == 1'b0, "R3 flag bits", d[19:16], 5);
    chk(d[26:20] == 7'd77, "R3 source field", d[26:20], 77);
    chk(d[15:0] == 16'd7, "R3 duration field", d[15:0], 7);
    chk(d[31] == 1'b1, "R4 busy during run", d[31], 1);
    cyc = 0;
    do begin rd(4'h4, d); cyc++; end while (d[31] && cyc < 30000);
    rd(4'hC, d);
    chk(near(int'(d[15:0]), 1000), "R5 count 8us", d[15:0], 1000);
    chk(irq_cnt - base == 1, "R8 one irq", irq_cnt - base, 1);
    wr(4'h4, 32'h0);

    // R3 run without enable
    wr(4'h4, cw(3, 5, 0, 1, 0, 0));
    rd(4'h4, d); chk(d[19] == 1'b0 && d[31] == 1'b0, "R3 run needs enable", d[31:16], 0);
    // R4 busy not writable
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, d); chk(d == 0, "R4 busy read only", d, 0);

    // R1 result read-only, word 0 writes ignored
    rd(4'hC, d); r0 = int'(d);
    wr(4'hC, 32'h0000_1234);
    rd(4'hC, d); chk(int'(d) == r0, "R1 result write ignored", d, r0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h4, d); chk(d == 0, "R1 word0 write ignored", d, 0);

    // R6 saturation: 1 GHz over 70 us
    run_meas(127, 69, 1'b0, cyc, res);
    chk(res == 16'hFFFF, "R6 saturate", res, 16'hFFFF);

    // R9 abort mid window
    base = irq_cnt;
    rd(4'hC, d); r0 = int'(d);
    wr(4'h4, 32'h0);
    wr(4'h4, cw(3, 49, 1, 1, 0, 1));
    repeat (4000) @(negedge clk);
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk(d[31] == 1'b0, "R9 busy drops", d[31], 0);
    repeat (8000) @(negedge clk);
    rd(4'hC, d); chk(int'(d) == r0, "R9 result kept", d, r0);
    chk(irq_cnt == base, "R9 no irq", irq_cnt - base, 0);
    run_meas(77, 3, 1'b0, cyc, res);
    chk(near(res, 500), "R9 next measurement", res, 500);

    // R7 continuous
    base = irq_cnt;
    wr(4'h4, 32'h0);
    wr(4'h4, cw(77, 1, 1, 1, 1, 1));
    cyc = 0;
    while (irq_cnt < base + 3 && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(irq_cnt - base >= 3, "R7 repeated completions", irq_cnt - base, 3);
    rd(4'h4, d); chk(d[31] == 1'b1, "R7 busy while continuous", d[31], 1);
    rd(4'hC, d); chk(near(int'(d[15:0]), 250), "R7 result", d[15:0], 250);
    wr(4'h4, 32'h0);
    repeat (200) @(negedge clk);
    base = irq_cnt;
    repeat (1500) @(negedge clk);
    chk(irq_cnt == base, "R7 stopped", irq_cnt - base, 0);
    rd(4'h4, d); chk(d == 0, "R7 idle after stop", d, 0);
    chk(width_err == 0, "R8 pulse width", width_err, 0);

    summary();
    $finish;
  end
endmodule